// File: doc/BRIEF.md
# Periodic Tick Timer

A 24-bit down-counting timer that marks out a fixed period for an operating system scheduler or any other periodic software task. Software programs a reload value and enables the timer. The counter then steps down by one on every tick and wraps back to the reload value, so each period lasts reload+1 ticks. Each wrap sets a sticky flag, and it can also send a one-cycle request to an interrupt controller.

The tick source is selectable. It is either every cycle of the core clock or a single-cycle enable strobe from an external slower reference. Software reaches four word registers through a simple 32-bit bus: control/status, reload, current value, and a read-only calibration constant. The bus takes one access per cycle. Read data is combinational during the request cycle, and register updates take effect at the clock edge that ends the request.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers read 0 and `irq_o` is low.
- R2: A write to control (offset 0x0) updates only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (source, 1 = core clock, 0 = `ref_tick_i`). The wrap flag in bit 16 and all other bits are not changed by the written data.
- R3: A read of control returns the current value, with the wrap flag in bit 16. The flag then reads 0 on a following read, unless a new wrap has occurred.
- R4: While enabled, the counter decrements once per tick, and wraps occur every reload+1 ticks.
- R5: A wrap sets the flag. `irq_o` pulses high for exactly one cycle on a wrap only when interrupt enable is 1. The pulse is visible after the edge at which the count expires.
- R6: When the count expires with a reload value of 0, hardware clears the enable bit and counting stops.
- R7: Any write to current value (offset 0x8) loads the counter from the reload register and clears the wrap flag. The written data is ignored.
- R8: A read of current value returns 0 while disabled, and it returns 0 when the count exceeds the reload value.
- R9: Disabling freezes the remaining count, and re-enabling resumes from it. After hardware has stopped the timer (R6), enabling loads a fresh count from the reload register.
- R10: A control write that changes the source bit but leaves enable unchanged restarts the count from the reload value.
- R11: With source 0, the counter moves only in cycles where `ref_tick_i` is high.
- R12: Calibration (offset 0xC) always reads 10000 and ignores writes. Reload (offset 0x4) keeps 24 bits, and bits 31:24 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | External reference tick enable, one cycle per tick |
| req_i | input | 1 | Bus access request, one word per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address, bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request |
| irq_o | output | 1 | Wrap interrupt request, one-cycle pulse |

## Verification
A corrupted count shows up at the ports as an interrupt pulse one or more cycles off the reload+1 rhythm, within a single period. It also shows up as a wrong current-value read at the next access. A fault in the enable or live state, for example resuming when a fresh load is due or failing to stop on a zero reload, shows in the first period after the control write. It appears as a missing, early or extra pulse, or as a control read with the wrong enable bit. A flag that is lost or stuck is visible at the very next control read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W = 32;

  // word index of each register (addr bits 3:2)
  localparam logic [1:0] IDX_CTL = 2'd0;
  localparam logic [1:0] IDX_RLD = 2'd1;
  localparam logic [1:0] IDX_CUR = 2'd2;
  localparam logic [1:0] IDX_CAL = 2'd3;

  // control register bit positions
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_SRC  = 2;
  localparam int unsigned CTL_FLAG = 16;

  typedef struct packed {
    logic ctl_wr;
    logic ctl_rd;
    logic rld_wr;
    logic cur_wr;
  } tt_stb_t;
endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
  import tick_timer_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] idx_i,
  output tt_stb_t    stb_o
);
  always_comb begin
    stb_o        = '0;
    stb_o.ctl_wr = req_i &  we_i & (idx_i == IDX_CTL);
    stb_o.ctl_rd = req_i & ~we_i & (idx_i == IDX_CTL);
    stb_o.rld_wr = req_i &  we_i & (idx_i == IDX_RLD);
    stb_o.cur_wr = req_i &  we_i & (idx_i == IDX_CUR);
  end
endmodule

// File: rtl/tick_timer_reload.sv
module tick_timer_reload #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o
);
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reload_q <= '0;
    else if (wr_i) reload_q <= wdata_i;
  end

  assign reload_o = reload_q;

  p_reload_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(reload_q));
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  tt_stb_t          stb_i,
  input  logic [2:0]       ctl_wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             en_o,
  output logic             ie_o,
  output logic             src_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic             en_q, ie_q, src_q, flag_q, live_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, expire, bus_load;

  // a control or current-value write owns the cycle; no tick is taken
  assign bus_load = stb_i.ctl_wr | stb_i.cur_wr;
  assign tick     = en_q & (src_q | ref_tick_i) & ~bus_load;
  assign expire   = tick & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      src_q  <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire & ie_q;
      if (stb_i.ctl_wr) begin
        en_q  <= ctl_wdata_i[CTL_EN];
        ie_q  <= ctl_wdata_i[CTL_IE];
        src_q <= ctl_wdata_i[CTL_SRC];
        if (ctl_wdata_i[CTL_EN] != en_q) begin
          if (ctl_wdata_i[CTL_EN] && !live_q) begin
            cnt_q  <= reload_i;
            live_q <= 1'b1;
          end
        end else if (ctl_wdata_i[CTL_SRC] != src_q) begin
          cnt_q  <= reload_i;
          live_q <= 1'b1;
        end
      end else if (stb_i.cur_wr) begin
        cnt_q  <= reload_i;
        live_q <= 1'b1;
      end else if (tick) begin
        if (cnt_q == '0) begin
          if (reload_i == '0) begin
            en_q   <= 1'b0;
            live_q <= 1'b0;
          end else begin
            cnt_q <= reload_i;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // set wins over read-clear so a wrap is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           flag_q <= 1'b0;
    else if (expire)                       flag_q <= 1'b1;
    else if (stb_i.ctl_rd | stb_i.cur_wr)  flag_q <= 1'b0;
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign src_o  = src_q;
  assign flag_o = flag_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  p_irq_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag_q);
  p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_zero_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload_i == '0) |=> !en_q);
  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !bus_load) |=> $stable(cnt_q));
  p_cur_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.cur_wr |=> (cnt_q == $past(reload_i)) && !flag_q);
  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.ctl_rd && !expire) |=> !flag_q);
  p_ctl_keep_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.ctl_wr && !expire) |=> flag_q == $past(flag_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  tt_stb_t          stb;
  logic [1:0]       idx;
  logic [CNT_W-1:0] reload, cnt;
  logic             en, ie, src, flag;
  logic [DATA_W-1:0] ctl_val, cur_val;
  logic             unused_bits;

  assign idx         = addr_i[3:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CNT_W]};

  tick_timer_decode u_decode (
    .req_i (req_i),
    .we_i  (we_i),
    .idx_i (idx),
    .stb_o (stb)
  );

  tick_timer_reload #(.CNT_W(CNT_W)) u_reload (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (stb.rld_wr),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .reload_o (reload)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_tick_i  (ref_tick_i),
    .stb_i       (stb),
    .ctl_wdata_i (wdata_i[2:0]),
    .reload_i    (reload),
    .en_o        (en),
    .ie_o        (ie),
    .src_o       (src),
    .flag_o      (flag),
    .cnt_o       (cnt),
    .irq_o       (irq_o)
  );

  always_comb begin
    ctl_val           = '0;
    ctl_val[CTL_EN]   = en;
    ctl_val[CTL_IE]   = ie;
    ctl_val[CTL_SRC]  = src;
    ctl_val[CTL_FLAG] = flag;
  end

  assign cur_val = (en && cnt <= reload) ? {{PAD_W{1'b0}}, cnt} : '0;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (idx)
        IDX_CTL: rdata_o = ctl_val;
        IDX_RLD: rdata_o = {{PAD_W{1'b0}}, reload};
        IDX_CUR: rdata_o = cur_val;
        default: rdata_o = DATA_W'(CAL_VALUE);
      endcase
    end
  end

  p_idle_rdata_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == '0);
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  localparam logic [3:0] A_CTL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  always #5 clk = ~clk;

  tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  function automatic logic [31:0] ctl_word(input logic f, input logic s, input logic i, input logic e);
    return {15'b0, f, 13'b0, s, i, e};
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    rd(A_RLD, v); chk("R1 reload", v, 0);
    rd(A_CUR, v); chk("R1 cur", v, 0);
    chk("R1 irq", irq, 0);

    // R12 calibration and reload width
    wr(A_CAL, 32'h1234); rd(A_CAL, v); chk("R12 cal", v, 10000);
    wr(A_RLD, 32'hFFFF_FFFF); rd(A_RLD, v); chk("R12 reload width", v, 32'h00FF_FFFF);

    // R2 only bits 2:0 written
    wr(A_CTL, 32'hFFFF_0000); rd(A_CTL, v); chk("R2 upper ignored", v, 0);

    // R4/R5 period with interrupt, reload 5
    wr(A_RLD, 5); wr(A_CUR, 0); wr(A_CTL, 7);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      chk("R4 R5 irq timing", irq, (k == 6 || k == 12));
    end
    wr(A_CTL, 6);
    rd(A_CTL, v); chk("R2 R3 flag kept on write", v, ctl_word(1, 1, 1, 0));
    rd(A_CTL, v); chk("R3 flag cleared by read", v, ctl_word(0, 1, 1, 0));
    rd(A_CUR, v); chk("R8 disabled reads 0", v, 0);

    // R5 no interrupt with ie=0, flag still set
    wr(A_RLD, 3); wr(A_CUR, 0); wr(A_CTL, 5);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk("R5 no irq when ie=0", seen, 0);
    wr(A_CTL, 4);
    rd(A_CTL, v); chk("R5 flag set", v, ctl_word(1, 1, 0, 0));

    // R9 freeze and resume
    wr(A_RLD, 20); wr(A_CUR, 0); wr(A_CTL, 5);
    rd(A_CUR, v); chk("R4 cur counts", v, 19);
    wr(A_CTL, 4);
    rd(A_CUR, v); chk("R8 cur disabled", v, 0);
    repeat (5) @(negedge clk);
    wr(A_CTL, 5);
    rd(A_CUR, v); chk("R9 resume", v, 16);

    // R10 source change restarts; R11 ref ticks only
    wr(A_CTL, 1);
    rd(A_CUR, v); chk("R10 restart", v, 20);
    repeat (5) @(negedge clk);
    rd(A_CUR, v); chk("R11 no ref no count", v, 20);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    rd(A_CUR, v); chk("R11 one ref tick", v, 19);
    wr(A_RLD, 5);
    rd(A_CUR, v); chk("R8 above reload", v, 0);
    wr(A_CTL, 0);

    // R7 current write reloads, data ignored, flag cleared
    wr(A_RLD, 3); wr(A_CUR, 32'h00AB_CDEF); wr(A_CTL, 7);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R7 reload from register", irq, (k == 4));
    end
    wr(A_CUR, 0);
    rd(A_CTL, v); chk("R7 flag cleared", v, ctl_word(0, 1, 1, 1));

    // R6 zero reload stops
    wr(A_RLD, 0);
    repeat (12) @(negedge clk);
    wr(A_CTL, 32'hFFFE_FFF6);
    rd(A_CTL, v); chk("R6 R2 enable cleared", v, ctl_word(1, 1, 1, 0));
    rd(A_CUR, v); chk("R6 cur stopped", v, 0);

    // R9 fresh load after hardware stop
    wr(A_RLD, 2); wr(A_CTL, 7);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R9 fresh load", irq, (k == 3));
    end
    wr(A_CTL, 0);

    // R4 R11 random periods and reference patterns
    for (int t = 0; t < 8; t++) begin
      int n, ticks, got;
      logic s, refq;
      n = 1 + int'($urandom % 12);
      s = 1'($urandom % 2);
      ref_tick = 1'b0;
      wr(A_CTL, 0); wr(A_RLD, n); wr(A_CUR, 0);
      wr(A_CTL, {29'b0, s, 2'b11});
      ticks = 0; got = 0; refq = 1'b0;
      for (int c = 0; c < 400 && got < 3; c++) begin
        logic exp;
        @(negedge clk);
        if (s || refq) ticks++;
        exp = (ticks == n + 1);
        chk(s ? "R4 random period" : "R11 random ref", irq, exp);
        if (exp) begin ticks = 0; got++; end
        ref_tick = s ? 1'b0 : ($urandom % 3 == 0);
        refq = ref_tick;
      end
      chk("R4 wraps seen", got, 3);
      ref_tick = 1'b0;
      wr(A_CTL, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule